// File: doc/BRIEF.md
# Memory-Mapped Console Register Controller

This block is the register front end of a simple serial console. Software reaches it through a 32-bit register window of 0x24 bytes. A byte stream from a character source fills a receive FIFO. A register write sends one byte straight out on a transmit byte stream. A level interrupt reports that received data is waiting while interrupts are enabled. Software can also store a 64-bit buffer address and a 32-bit length for a separate transfer engine.

Commands go to a single command register. Two of them switch interrupts off or on. The other two start a buffer transfer in one of two directions: memory to transmit stream, or receive FIFO to memory. The block does not move buffer data itself. It pulses a start strobe with the direction, exposes the stored address and length, and stays busy until the engine answers with a done pulse. During a FIFO-to-memory transfer the engine drains the receive FIFO through a pop port.

Top module: `console_mmio_ctrl`

## Requirements
- R1: While reset is asserted and right after it: the FIFO is empty (count 0, `rx_ready` 1), interrupts are disabled (`irq` 0), the stored address and length are 0, and `tx_valid` and `xfer_start` are 0.
- R2: A write to offset 0x00 drives `tx_valid` high for exactly the next cycle, with `tx_data` equal to bits 7:0 of the write data.
- R3: When `bus_rd` is high, `bus_rdata` shows a combinational value. Offset 0x20 returns 1. Offset 0x04 returns the number of bytes in the receive FIFO. Every other offset, including the writable ones and offsets from 0x24 up, returns 0. With `bus_rd` low, `bus_rdata` is 0.
- R4: `rx_ready` is high exactly when the FIFO holds fewer than `RX_DEPTH` bytes. A byte offered with `rx_valid` while `rx_ready` is high is stored at the tail. A byte offered while the FIFO is full is dropped.
- R5: A command write with value 2 or 3 pulses `xfer_start` for one cycle, in the cycle after the write. `xfer_dir` is 0 for value 2 (memory to transmit) and 1 for value 3 (FIFO to memory). The block then stays busy until a cycle in which `xfer_done` is high.
- R6: While busy, every command write is ignored: no start, and no change to the interrupt enable. Command values other than 0, 1, 2 and 3 (the full 32-bit word is compared) are always ignored.
- R7: Offset 0x10 loads bits 31:0 of `xfer_ptr`. Offset 0x18 replaces bits 63:32 and keeps bits 31:0. Offset 0x14 loads `xfer_len`.
- R8: `irq` is high exactly when interrupts are enabled and the FIFO is non-empty. Command 1 enables interrupts and command 0 disables them. Each takes effect in the cycle after the write, and repeating the current state changes nothing.
- R9: `xfer_byte_valid` is high only while busy with `xfer_dir` = 1 and the FIFO is non-empty. `xfer_byte` is then the oldest byte, and a cycle with `xfer_pop` high removes it. A pop at any other time leaves the FIFO unchanged.
- R10: An access with address bits 1:0 not both zero is ignored. A read returns 0, and a write changes no register and issues no byte or command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 6 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| rx_valid | input | 1 | Incoming byte valid |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | FIFO has room |
| tx_valid | output | 1 | Immediate transmit byte strobe |
| tx_data | output | 8 | Immediate transmit byte |
| irq | output | 1 | Level interrupt |
| xfer_start | output | 1 | One-cycle transfer start |
| xfer_dir | output | 1 | 0 memory to transmit, 1 FIFO to memory |
| xfer_ptr | output | 64 | Stored buffer address |
| xfer_len | output | 32 | Stored buffer length |
| xfer_done | input | 1 | Transfer engine finished |
| xfer_pop | input | 1 | Engine takes the head FIFO byte |
| xfer_byte | output | 8 | Head FIFO byte |
| xfer_byte_valid | output | 1 | Head byte may be popped |

## Verification
The bench builds the block with `RX_DEPTH` = 5. A few receive bytes are then enough to fill the FIFO, so the full and drop conditions come up often. Because 5 is not a power of two, the read and write pointers must wrap at a bound that is not a binary rollover. Random traffic mixes pushes, pops, done pulses and command writes while a transfer is busy, so a full FIFO, a pop from an empty FIFO and commands refused while busy all appear many times.

// File: rtl/console_pkg.sv
package console_pkg;

  localparam int unsigned AW = 6;

  // Word offsets inside the register window
  localparam logic [AW-1:0] OFS_TX     = 6'h00;
  localparam logic [AW-1:0] OFS_COUNT  = 6'h04;
  localparam logic [AW-1:0] OFS_CMD    = 6'h08;
  localparam logic [AW-1:0] OFS_PTR_LO = 6'h10;
  localparam logic [AW-1:0] OFS_LEN    = 6'h14;
  localparam logic [AW-1:0] OFS_PTR_HI = 6'h18;
  localparam logic [AW-1:0] OFS_VER    = 6'h20;
  localparam logic [AW-1:0] WINDOW     = 6'h24;

  localparam logic [31:0] CONSOLE_VERSION = 32'd1;

  // Command codes
  localparam logic [31:0] CMD_IRQ_OFF     = 32'd0;
  localparam logic [31:0] CMD_IRQ_ON      = 32'd1;
  localparam logic [31:0] CMD_MEM_TO_TX   = 32'd2;
  localparam logic [31:0] CMD_FIFO_TO_MEM = 32'd3;

  typedef enum logic {
    DIR_MEM_TO_TX   = 1'b0,
    DIR_FIFO_TO_MEM = 1'b1
  } xfer_dir_e;

  typedef struct packed {
    logic tx;
    logic cmd;
    logic ptr_lo;
    logic len;
    logic ptr_hi;
  } wr_sel_t;

  typedef struct packed {
    logic count;
    logic ver;
  } rd_sel_t;

endpackage

// File: rtl/console_addr_dec.sv
module console_addr_dec
  import console_pkg::*;
(
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic          rd_en,
  output wr_sel_t       wsel,
  output rd_sel_t       rsel
);

  logic aligned;

  // Only whole-word accesses inside the window decode
  assign aligned = (addr[1:0] == 2'b00) && (addr < WINDOW);

  always_comb begin
    wsel = '0;
    rsel = '0;
    if (aligned && wr_en) begin
      case (addr)
        OFS_TX:     wsel.tx     = 1'b1;
        OFS_CMD:    wsel.cmd    = 1'b1;
        OFS_PTR_LO: wsel.ptr_lo = 1'b1;
        OFS_LEN:    wsel.len    = 1'b1;
        OFS_PTR_HI: wsel.ptr_hi = 1'b1;
        default:    ;
      endcase
    end
    if (aligned && rd_en) begin
      case (addr)
        OFS_COUNT: rsel.count = 1'b1;
        OFS_VER:   rsel.ver   = 1'b1;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/console_rx_fifo.sv
module console_rx_fifo #(
  parameter  int unsigned DEPTH  = 16,
  parameter  int unsigned BYTE_W = 8,
  localparam int unsigned PW     = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_data,
  output logic              in_ready,
  input  logic              pop,
  output logic [BYTE_W-1:0] head,
  output logic              empty,
  output logic [CW-1:0]     count
);

  logic [BYTE_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic              push, pull;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready = (cnt_q != CW'(DEPTH));
  assign empty    = (cnt_q == '0);
  assign count    = cnt_q;
  assign push     = in_valid & in_ready;
  assign pull     = pop & ~empty;
  assign head     = mem[rd_q];

  always_comb begin
    wr_d  = push ? wrap_inc(wr_q) : wr_q;
    rd_d  = pull ? wrap_inc(rd_q) : rd_q;
    cnt_d = cnt_q;
    case ({push, pull})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  // Storage entries, each with its own write enable
  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (push && (wr_q == PW'(i))) begin
        mem[i] <= in_data;
      end
    end
  end

  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  a_r4_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pull) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r9_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (pull && !push) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/console_cmd_ctrl.sv
module console_cmd_ctrl
  import console_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_val,
  input  logic        xfer_done,
  output logic        int_en,
  output logic        busy,
  output logic        start,
  output xfer_dir_e   dir
);

  logic      en_q, en_d;
  logic      busy_q, busy_d;
  logic      start_q, start_d;
  xfer_dir_e dir_q, dir_d;
  logic      accept;

  assign accept = cmd_wr & ~busy_q;

  always_comb begin
    en_d    = en_q;
    start_d = 1'b0;
    dir_d   = dir_q;
    if (accept) begin
      case (cmd_val)
        CMD_IRQ_OFF:     en_d = 1'b0;
        CMD_IRQ_ON:      en_d = 1'b1;
        CMD_MEM_TO_TX: begin
          start_d = 1'b1;
          dir_d   = DIR_MEM_TO_TX;
        end
        CMD_FIFO_TO_MEM: begin
          start_d = 1'b1;
          dir_d   = DIR_FIFO_TO_MEM;
        end
        default: ;
      endcase
    end
    if (start_d) begin
      busy_d = 1'b1;
    end else if (xfer_done) begin
      busy_d = 1'b0;
    end else begin
      busy_d = busy_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      dir_q   <= DIR_MEM_TO_TX;
    end else begin
      en_q    <= en_d;
      busy_q  <= busy_d;
      start_q <= start_d;
      dir_q   <= dir_d;
    end
  end

  assign int_en = en_q;
  assign busy   = busy_q;
  assign start  = start_q;
  assign dir    = dir_q;

  a_r6_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && busy_q) |=> (!start_q && $stable(en_q)));

  a_r5_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

  a_r5_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !xfer_done) |=> busy_q);

endmodule

// File: rtl/console_data_regs.sv
module console_data_regs
  import console_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  wr_sel_t     wsel,
  input  logic [31:0] wdata,
  output logic [63:0] ptr,
  output logic [31:0] len,
  output logic        tx_valid,
  output logic [7:0]  tx_data
);

  logic [63:0] ptr_q, ptr_d;
  logic [31:0] len_q, len_d;
  logic        txv_q, txv_d;
  logic [7:0]  txd_q, txd_d;

  always_comb begin
    ptr_d = ptr_q;
    if (wsel.ptr_lo) ptr_d[31:0]  = wdata;
    if (wsel.ptr_hi) ptr_d[63:32] = wdata;
    len_d = wsel.len ? wdata : len_q;
    txv_d = wsel.tx;
    txd_d = wsel.tx ? wdata[7:0] : txd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      len_q <= '0;
      txv_q <= 1'b0;
      txd_q <= '0;
    end else begin
      ptr_q <= ptr_d;
      len_q <= len_d;
      txv_q <= txv_d;
      txd_q <= txd_d;
    end
  end

  assign ptr      = ptr_q;
  assign len      = len_q;
  assign tx_valid = txv_q;
  assign tx_data  = txd_q;

  a_r7_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (wsel.ptr_hi && !wsel.ptr_lo) |=> (ptr_q[31:0] == $past(ptr_q[31:0])));

  a_r2_tx_follows_write: assert property (@(posedge clk) disable iff (!rst_n)
    wsel.tx |=> (txv_q && (txd_q == $past(wdata[7:0]))));

endmodule

// File: rtl/console_mmio_ctrl.sv
module console_mmio_ctrl
  import console_pkg::*;
#(
  parameter  int unsigned RX_DEPTH = 16,
  localparam int unsigned CNT_W    = $clog2(RX_DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [5:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        irq,
  output logic        xfer_start,
  output logic        xfer_dir,
  output logic [63:0] xfer_ptr,
  output logic [31:0] xfer_len,
  input  logic        xfer_done,
  input  logic        xfer_pop,
  output logic [7:0]  xfer_byte,
  output logic        xfer_byte_valid
);

  wr_sel_t          wsel;
  rd_sel_t          rsel;
  logic             int_en, busy, fifo_empty, drain_ok;
  xfer_dir_e        dir;
  logic [CNT_W-1:0] fill;

  console_addr_dec u_dec (
    .addr  (bus_addr),
    .wr_en (bus_wr),
    .rd_en (bus_rd),
    .wsel  (wsel),
    .rsel  (rsel)
  );

  console_data_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wsel     (wsel),
    .wdata    (bus_wdata),
    .ptr      (xfer_ptr),
    .len      (xfer_len),
    .tx_valid (tx_valid),
    .tx_data  (tx_data)
  );

  console_cmd_ctrl u_cmd (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (wsel.cmd),
    .cmd_val   (bus_wdata),
    .xfer_done (xfer_done),
    .int_en    (int_en),
    .busy      (busy),
    .start     (xfer_start),
    .dir       (dir)
  );

  assign drain_ok = busy & (dir == DIR_FIFO_TO_MEM);

  console_rx_fifo #(
    .DEPTH  (RX_DEPTH),
    .BYTE_W (8)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (rx_valid),
    .in_data  (rx_data),
    .in_ready (rx_ready),
    .pop      (xfer_pop & drain_ok),
    .head     (xfer_byte),
    .empty    (fifo_empty),
    .count    (fill)
  );

  assign xfer_dir        = dir;
  assign xfer_byte_valid = drain_ok & ~fifo_empty;
  assign irq             = int_en & ~fifo_empty;

  always_comb begin
    bus_rdata = '0;
    if (rsel.count) bus_rdata = 32'(fill);
    if (rsel.ver)   bus_rdata = CONSOLE_VERSION;
  end

  a_r8_arrival_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && rx_valid && rx_ready && !bus_wr) |=> irq);

  a_r10_misaligned_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr[1:0] != 2'b00)) |=>
      ($stable(xfer_ptr) && $stable(xfer_len) && !tx_valid && !xfer_start));

  a_r9_no_drain_outside: assert property (@(posedge clk) disable iff (!rst_n)
    (!drain_ok && !rx_valid) |=> $stable(fill));

endmodule

// File: tb/console_mmio_ctrl_tb.sv
`timescale 1ns/1ps
module console_mmio_ctrl_tb;

  localparam int DEPTH = 5;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        rx_ready, tx_valid;
  logic [7:0]  tx_data;
  logic        irq, xfer_start, xfer_dir;
  logic [63:0] xfer_ptr;
  logic [31:0] xfer_len;
  logic        xfer_done, xfer_pop;
  logic [7:0]  xfer_byte;
  logic        xfer_byte_valid;

  always #2.5 clk = ~clk;

  console_mmio_ctrl #(.RX_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq),
    .xfer_start(xfer_start), .xfer_dir(xfer_dir), .xfer_ptr(xfer_ptr),
    .xfer_len(xfer_len), .xfer_done(xfer_done), .xfer_pop(xfer_pop),
    .xfer_byte(xfer_byte), .xfer_byte_valid(xfer_byte_valid)
  );

  // Reference model state
  logic [7:0]  q[$];
  bit          m_en, m_busy, m_dir, m_txv, m_start;
  logic [7:0]  m_txd;
  logic [63:0] m_ptr;
  logic [31:0] m_len;
  int          checks = 0;
  int          errors = 0;
  bit          finished = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic bit is_aligned(input logic [5:0] a);
    return (a[1:0] == 2'b00) && (a < 6'h24);
  endfunction

  function automatic logic [31:0] exp_read(input bit rd, input logic [5:0] a, input int fill);
    if (!rd || !is_aligned(a)) return 32'd0;
    if (a == 6'h04) return 32'(fill);
    if (a == 6'h20) return 32'd1;
    return 32'd0;
  endfunction

  task automatic check_state();
    chk("R8 irq level", irq, 64'(m_en && (q.size() > 0)));
    chk("R2 tx_valid", tx_valid, 64'(m_txv));
    if (m_txv) chk("R2 tx_data", tx_data, m_txd);
    chk("R5 xfer_start", xfer_start, 64'(m_start));
    if (m_start) chk("R5 xfer_dir", xfer_dir, 64'(m_dir));
    chk("R7 xfer_ptr", xfer_ptr, m_ptr);
    chk("R7 xfer_len", xfer_len, 64'(m_len));
  endtask

  // One clock cycle; called at a falling edge, returns at the next one
  task automatic cyc(input bit wr, input bit rd, input logic [5:0] a, input logic [31:0] d,
                     input bit rv, input logic [7:0] rb, input bit pop, input bit done);
    bit full_pre, popable, al;
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    rx_valid = rv; rx_data = rb; xfer_pop = pop; xfer_done = done;
    #1;
    al = is_aligned(a);
    chk("R3 R10 read data", bus_rdata, 64'(exp_read(rd, a, q.size())));
    full_pre = (q.size() >= DEPTH);
    chk("R4 rx_ready", rx_ready, 64'(!full_pre));
    popable = m_busy && m_dir && (q.size() > 0);
    chk("R9 byte valid", xfer_byte_valid, 64'(popable));
    if (popable) chk("R9 head byte", xfer_byte, q[0]);
    // next state of the model
    m_txv   = wr && al && (a == 6'h00);
    if (m_txv) m_txd = d[7:0];
    m_start = 1'b0;
    if (wr && al && (a == 6'h08) && !m_busy) begin
      case (d)
        32'd0: m_en = 1'b0;
        32'd1: m_en = 1'b1;
        32'd2: begin m_start = 1'b1; m_dir = 1'b0; end
        32'd3: begin m_start = 1'b1; m_dir = 1'b1; end
        default: ;
      endcase
    end
    if (popable && pop) void'(q.pop_front());
    if (rv && !full_pre) q.push_back(rb);
    if (m_start) m_busy = 1'b1;
    else if (done) m_busy = 1'b0;
    if (wr && al && (a == 6'h10)) m_ptr[31:0]  = d;
    if (wr && al && (a == 6'h18)) m_ptr[63:32] = d;
    if (wr && al && (a == 6'h14)) m_len = d;
    @(negedge clk);
    check_state();
  endtask

  task automatic wr_reg(input logic [5:0] a, input logic [31:0] d);
    cyc(1, 0, a, d, 0, 8'h00, 0, 0);
  endtask

  task automatic rd_reg(input logic [5:0] a);
    cyc(0, 1, a, 32'h0, 0, 8'h00, 0, 0);
  endtask

  task automatic push(input logic [7:0] b);
    cyc(0, 0, 6'h00, 32'h0, 1, b, 0, 0);
  endtask

  localparam logic [5:0] PICK [12] = '{6'h00, 6'h04, 6'h08, 6'h08, 6'h08, 6'h10,
                                      6'h14, 6'h18, 6'h20, 6'h24, 6'h2c, 6'h09};

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    bus_wr = 0; bus_rd = 1; bus_addr = 6'h04; bus_wdata = '0;
    rx_valid = 0; rx_data = '0; xfer_pop = 0; xfer_done = 0;
    m_en = 0; m_busy = 0; m_dir = 0; m_txv = 0; m_start = 0; m_txd = '0;
    m_ptr = '0; m_len = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 count", bus_rdata, 64'd0);
    chk("R1 rx_ready", rx_ready, 64'd1);
    chk("R1 irq", irq, 64'd0);
    chk("R1 tx_valid", tx_valid, 64'd0);
    chk("R1 xfer_start", xfer_start, 64'd0);
    chk("R1 xfer_ptr", xfer_ptr, 64'd0);
    chk("R1 xfer_len", xfer_len, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state();

    // R7: pointer halves and length
    wr_reg(6'h10, 32'h1234_5678);
    wr_reg(6'h18, 32'hDEAD_BEEF);
    wr_reg(6'h10, 32'hAAAA_0000);
    wr_reg(6'h18, 32'h0000_0001);
    wr_reg(6'h14, 32'h0000_0400);
    // R2: immediate byte
    wr_reg(6'h00, 32'hABCD_EF5A);
    // R3 and R10: reads
    rd_reg(6'h20); rd_reg(6'h04); rd_reg(6'h10); rd_reg(6'h24); rd_reg(6'h21);
    cyc(0, 0, 6'h20, 32'h0, 0, 8'h00, 0, 0);
    // R10: misaligned writes change nothing
    wr_reg(6'h11, 32'hFFFF_FFFF);
    wr_reg(6'h01, 32'h0000_0077);
    wr_reg(6'h09, 32'h0000_0001);
    // R4: fill past depth, last byte dropped
    for (int i = 0; i < DEPTH + 1; i++) push(8'h30 + 8'(i));
    rd_reg(6'h04);
    // R8: enable edges
    wr_reg(6'h08, 32'd1);
    wr_reg(6'h08, 32'd1);
    wr_reg(6'h08, 32'd0);
    wr_reg(6'h08, 32'd0);
    wr_reg(6'h08, 32'd1);
    // R5 and R6: start drain, refuse commands while busy
    wr_reg(6'h08, 32'd3);
    wr_reg(6'h08, 32'd2);
    wr_reg(6'h08, 32'd0);
    // R9: pop two bytes
    cyc(0, 0, 6'h00, 32'h0, 0, 8'h00, 1, 0);
    cyc(0, 0, 6'h00, 32'h0, 0, 8'h00, 1, 1);
    // R9: pop after done ignored
    cyc(0, 1, 6'h04, 32'h0, 0, 8'h00, 1, 0);
    // R6: undefined command ignored
    wr_reg(6'h08, 32'd7);
    wr_reg(6'h08, 32'h0000_0101);
    // R9: pop during mem-to-tx transfer ignored
    wr_reg(6'h08, 32'd2);
    cyc(0, 1, 6'h04, 32'h0, 0, 8'h00, 1, 0);
    cyc(0, 0, 6'h00, 32'h0, 0, 8'h00, 0, 1);
    // R8: drain all, irq drops
    wr_reg(6'h08, 32'd3);
    for (int i = 0; i < DEPTH; i++) cyc(0, 0, 6'h00, 32'h0, 0, 8'h00, 1, 0);
    cyc(0, 1, 6'h04, 32'h0, 0, 8'h00, 0, 1);

    // Random traffic
    for (int n = 0; n < 4000; n++) begin
      int unsigned kind;
      logic [31:0] d;
      kind = $urandom % 10;
      d = ($urandom % 3 == 0) ? $urandom : ($urandom % 5);
      cyc(kind < 3, (kind >= 3) && (kind < 5), PICK[$urandom % 12], d,
          ($urandom % 2) == 0, 8'($urandom), ($urandom % 5) < 2, ($urandom % 10) == 0);
    end

    bus_wr = 0; bus_rd = 0; rx_valid = 0; xfer_pop = 0; xfer_done = 0;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule